// File: doc/BRIEF.md
# Quadrature to Up/Down Pulse Converter

This block takes two synchronous, already-filtered quadrature phase signals and turns their edges into two separate active-low pulse trains. One train carries forward steps and the other carries reverse steps. A level output shows the direction of the most recent legal step. A third active-low pulse marks the reference position given by an index input. That pulse starts in the same clock and lasts as long as the count pulse at that position, so a downstream up/down counter can use it as an absolute reference. Two mode pins select x1, x2 or x4 resolution.

The pulse length is a 16-bit count of system clocks. It is sampled when each pulse starts. It must be no longer than the shortest spacing between quadrature edges. A step in which both phases change at once is illegal: it makes no pulse and sets a sticky error flag, which only reset clears. The block runs on one clock with an active-high synchronous reset.

Top module: `quad_updn_conv`

## Requirements
- R1: Mode: `x2SelN` low selects x2 whatever `x4Sel` is. With `x2SelN` high, `x4Sel` low selects x1 and `x4Sel` high selects x4.
- R2: In x4 mode every legal edge of either phase makes one pulse. A leading B (AB sequence 00,10,11,01) drives `upClkN` low. A lagging B drives `dnClkN` low. The two are never low together.
- R3: In x2 mode both edges of A make a pulse and edges of B make none.
- R4: In x1 mode only A edges taken while B is low count. A rising is an up pulse and A falling is a down pulse.
- R5: `dirUp` is 1 for up and 0 for down. It changes on every legal edge in any mode, including edges that are not counted, and is 1 after reset.
- R6: A pulse goes low on the clock edge that samples the input change and stays low for `pulseWidth` clocks. A value of 0 acts as 1. The width is sampled when the pulse starts.
- R7: `idxOutN` pulses low on A rising while `idxIn` is 1 and B is 0, and on B falling while `idxIn` is 1 and A is 1. This holds in every mode.
- R8: An index pulse starts in the same clock as any count pulse at that edge and has the same width.
- R9: If A and B change in the same clock, no pulse is made and `dirUp` holds. `errSticky` goes to 1 and stays there until reset.
- R10: An event that arrives while a pulse is active ends that pulse: all outputs go high for one clock and the new pulse starts on the next clock. Events spaced at least two clocks apart are never lost.
- R11: During and right after reset, `upClkN`, `dnClkN` and `idxOutN` are 1, `dirUp` is 1 and `errSticky` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| inA | input | 1 | Quadrature phase A |
| inB | input | 1 | Quadrature phase B |
| idxIn | input | 1 | Index track level |
| x2SelN | input | 1 | Low selects x2 mode |
| x4Sel | input | 1 | With x2SelN high: 1 selects x4, 0 selects x1 |
| pulseWidth | input | 16 | Output pulse length in clocks (0 acts as 1) |
| upClkN | output | 1 | Active-low forward pulse |
| dnClkN | output | 1 | Active-low reverse pulse |
| idxOutN | output | 1 | Active-low index pulse |
| dirUp | output | 1 | Direction of the last legal step |
| errSticky | output | 1 | Set by a simultaneous A/B change |

## Verification
The hardest state to reach from the ports is a new edge arriving while a pulse is still low. This needs the edge spacing to be shorter than the programmed width, which legal use forbids. The stimulus reaches it with a directed run of edges every three clocks at a width of six. A random phase also mixes hold times of two to eight clocks with widths up to four, so it hits the retrigger gap, the release cycle and widths of zero. Illegal double-phase jumps and index-high windows are mixed into that random walk in every mode.

// File: rtl/qconv_pkg.sv
package qconv_pkg;

  typedef enum logic [1:0] {
    MODE_X1 = 2'd0,
    MODE_X2 = 2'd1,
    MODE_X4 = 2'd2
  } qmode_e;

  // strobes from control to datapath, one per output channel
  typedef struct packed {
    logic cntUp;
    logic cntDn;
    logic idx;
  } qstrobe_t;

  localparam int unsigned NUM_CHAN = 3;

endpackage

// File: rtl/qconv_ctrl.sv
module qconv_ctrl
  import qconv_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     inA,
  input  logic     inB,
  input  logic     idxIn,
  input  logic     x2SelN,
  input  logic     x4Sel,
  output qstrobe_t strb,
  output logic     dirUp,
  output logic     errSticky
);

  logic   prevA, prevB;
  logic   aEdge, bEdge, legalEdge, illegalStep;
  logic   edgeIsUp, countIt, idxHit;
  qmode_e mode;

  // x2 pin has priority over the x4/x1 pin
  always_comb begin
    if (!x2SelN)    mode = MODE_X2;
    else if (x4Sel) mode = MODE_X4;
    else            mode = MODE_X1;
  end

  assign aEdge       = inA ^ prevA;
  assign bEdge       = inB ^ prevB;
  assign illegalStep = aEdge & bEdge;
  assign legalEdge   = aEdge ^ bEdge;

  // forward order of AB is 00,10,11,01
  assign edgeIsUp = aEdge ? (inA ^ inB) : ~(inA ^ inB);

  always_comb begin
    countIt = 1'b0;
    unique case (mode)
      MODE_X4: countIt = legalEdge;
      MODE_X2: countIt = aEdge & ~bEdge;
      MODE_X1: countIt = aEdge & ~bEdge & ~inB;
      default: countIt = 1'b0;
    endcase
  end

  assign idxHit = idxIn & ((aEdge & ~bEdge & inA & ~inB) |
                           (bEdge & ~aEdge & ~inB & inA));

  assign strb.cntUp = countIt & edgeIsUp;
  assign strb.cntDn = countIt & ~edgeIsUp;
  assign strb.idx   = idxHit;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevA     <= inA;
      prevB     <= inB;
      dirUp     <= 1'b1;
      errSticky <= 1'b0;
    end else begin
      prevA <= inA;
      prevB <= inB;
      if (legalEdge)   dirUp     <= edgeIsUp;
      if (illegalStep) errSticky <= 1'b1;
    end
  end

  // R9: error flag never drops without reset
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    errSticky |=> errSticky);

  // R9: a double change produces no strobe
  a_r9_illegal_silent: assert property (@(posedge clk) disable iff (rst)
    (inA != prevA && inB != prevB) |-> (strb == '0));

  // R5: direction holds when no legal edge occurs
  a_r5_dir_hold: assert property (@(posedge clk) disable iff (rst)
    !legalEdge |=> $stable(dirUp));

  // R3: in x2 mode a lone B edge never counts
  a_r3_x2_ignores_b: assert property (@(posedge clk) disable iff (rst)
    (!x2SelN && (inB != prevB) && (inA == prevA)) |-> !(strb.cntUp || strb.cntDn));

endmodule

// File: rtl/qconv_datapath.sv
module qconv_datapath
  import qconv_pkg::*;
#(
  parameter int unsigned PW_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  qstrobe_t        strb,
  input  logic [PW_W-1:0] pulseWidth,
  output logic            upClkN,
  output logic            dnClkN,
  output logic            idxOutN
);

  localparam logic [PW_W-1:0] ONE = PW_W'(1);

  logic [NUM_CHAN-1:0] lowMask;
  logic [NUM_CHAN-1:0] pendMask;
  logic [NUM_CHAN-1:0] outN;
  logic [PW_W-1:0]     remCnt;
  logic [PW_W-1:0]     loadVal;
  logic                busy, pendValid, eventNow;

  assign eventNow = |strb;
  assign loadVal  = (pulseWidth == '0) ? '0 : (pulseWidth - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      lowMask   <= '0;
      pendMask  <= '0;
      remCnt    <= '0;
      busy      <= 1'b0;
      pendValid <= 1'b0;
    end else if (pendValid) begin
      lowMask   <= pendMask;
      remCnt    <= loadVal;
      busy      <= 1'b1;
      pendValid <= 1'b0;
    end else if (eventNow && busy) begin
      lowMask   <= '0;
      busy      <= 1'b0;
      pendMask  <= strb;
      pendValid <= 1'b1;
    end else if (eventNow) begin
      lowMask <= strb;
      remCnt  <= loadVal;
      busy    <= 1'b1;
    end else if (busy) begin
      if (remCnt == '0) begin
        lowMask <= '0;
        busy    <= 1'b0;
      end else begin
        remCnt <= remCnt - ONE;
      end
    end
  end

  for (genvar i = 0; i < NUM_CHAN; i++) begin : g_chan
    assign outN[i] = ~lowMask[i];
  end

  assign upClkN  = outN[2];
  assign dnClkN  = outN[1];
  assign idxOutN = outN[0];

  // R11: outputs idle high after a reset clock
  a_r11_reset_high: assert property (@(posedge clk)
    rst |=> (upClkN && dnClkN && idxOutN));

  // R2: up and down pulses never overlap
  a_r2_no_up_and_down: assert property (@(posedge clk) disable iff (rst)
    !(!upClkN && !dnClkN));

  // R10: an event during an active pulse forces a high gap
  a_r10_retrigger_gap: assert property (@(posedge clk) disable iff (rst)
    (busy && eventNow && !pendValid) |=> (upClkN && dnClkN && idxOutN));

  // R6: an idle event shows on the outputs after that edge
  a_r6_start_edge: assert property (@(posedge clk) disable iff (rst)
    (!busy && !pendValid && eventNow) |=> (~{upClkN, dnClkN, idxOutN} == $past(strb)));

endmodule

// File: rtl/quad_updn_conv.sv
module quad_updn_conv
  import qconv_pkg::*;
#(
  parameter int unsigned PW_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inA,
  input  logic            inB,
  input  logic            idxIn,
  input  logic            x2SelN,
  input  logic            x4Sel,
  input  logic [PW_W-1:0] pulseWidth,
  output logic            upClkN,
  output logic            dnClkN,
  output logic            idxOutN,
  output logic            dirUp,
  output logic            errSticky
);

  qstrobe_t strb;

  qconv_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inA       (inA),
    .inB       (inB),
    .idxIn     (idxIn),
    .x2SelN    (x2SelN),
    .x4Sel     (x4Sel),
    .strb      (strb),
    .dirUp     (dirUp),
    .errSticky (errSticky)
  );

  qconv_datapath #(.PW_W(PW_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .pulseWidth (pulseWidth),
    .upClkN     (upClkN),
    .dnClkN     (dnClkN),
    .idxOutN    (idxOutN)
  );

endmodule

// File: tb/quad_updn_conv_bench.sv
module quad_updn_conv_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inA = 1'b0, inB = 1'b0, idxIn = 1'b0;
  logic        x2SelN = 1'b1, x4Sel = 1'b1;
  logic [15:0] pulseWidth = 16'd3;
  logic        upClkN, dnClkN, idxOutN, dirUp, errSticky;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string phaseTag = "R11";

  // reference state
  bit          mPrevA, mPrevB, mDir, mErr;
  bit [2:0]    mLow;      // {up,dn,idx} asserted
  bit [2:0]    mPend;
  bit          mBusy, mPendV;
  int          mRem;
  int          pos = 0;

  always #2 clk = ~clk;

  quad_updn_conv u_quad_updn_conv (
    .clk(clk), .rst(rst), .inA(inA), .inB(inB), .idxIn(idxIn),
    .x2SelN(x2SelN), .x4Sel(x4Sel), .pulseWidth(pulseWidth),
    .upClkN(upClkN), .dnClkN(dnClkN), .idxOutN(idxOutN),
    .dirUp(dirUp), .errSticky(errSticky)
  );

  function automatic bit phaseA(input int p);
    return (p % 4 == 1) || (p % 4 == 2);
  endfunction
  function automatic bit phaseB(input int p);
    return (p % 4 == 2) || (p % 4 == 3);
  endfunction

  task automatic chk(input string tag, input string name, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    chk(phaseTag, "upClkN", upClkN, ~mLow[2]);
    chk(phaseTag, "dnClkN", dnClkN, ~mLow[1]);
    chk("R7", "idxOutN", idxOutN, ~mLow[0]);
    chk("R5", "dirUp", dirUp, mDir);
    chk("R9", "errSticky", errSticky, mErr);
  endtask

  // next state of the reference, from the requirements, for the coming edge
  task automatic modelStep();
    bit aE, bE, cnt, up, ix;
    bit [2:0] s;
    int w;
    if (rst) begin
      mPrevA = inA; mPrevB = inB; mDir = 1; mErr = 0;
      mLow = 0; mPend = 0; mBusy = 0; mPendV = 0; mRem = 0;
      return;
    end
    aE = inA ^ mPrevA; bE = inB ^ mPrevB;
    cnt = 0; up = 0; ix = 0;
    if (aE && bE) mErr = 1;
    else if (aE || bE) begin
      up = aE ? (inA != inB) : (inA == inB);
      mDir = up;
      if (!x2SelN)    cnt = aE;
      else if (x4Sel) cnt = 1;
      else            cnt = aE && !inB;
      ix = idxIn && ((aE && inA && !inB) || (bE && !inB && inA));
    end
    s = {cnt && up, cnt && !up, ix};
    w = (pulseWidth == 0) ? 1 : int'(pulseWidth);
    mPrevA = inA; mPrevB = inB;
    if (mPendV) begin
      mLow = mPend; mRem = w - 1; mBusy = 1; mPendV = 0;
    end else if (s != 0 && mBusy) begin
      mLow = 0; mBusy = 0; mPend = s; mPendV = 1;
    end else if (s != 0) begin
      mLow = s; mRem = w - 1; mBusy = 1;
    end else if (mBusy) begin
      if (mRem == 0) begin mLow = 0; mBusy = 0; end
      else mRem--;
    end
  endtask

  // inputs applied at negedge, checked at the following negedge
  task automatic cyc(input bit a, input bit b, input bit ix);
    inA = a; inB = b; idxIn = ix;
    modelStep();
    @(posedge clk);
    @(negedge clk);
    checkAll();
  endtask

  task automatic step(input int dir, input int hold, input bit ix);
    pos = (pos + dir + 4) % 4;
    cyc(phaseA(pos), phaseB(pos), ix);
    for (int k = 1; k < hold; k++) cyc(phaseA(pos), phaseB(pos), ix);
  endtask

  task automatic walk(input int dir, input int n, input int hold, input bit ix);
    for (int k = 0; k < n; k++) step(dir, hold, ix);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1; phaseTag = "R11";
    cyc(phaseA(pos), phaseB(pos), 0);
    cyc(phaseA(pos), phaseB(pos), 0);
    rst = 0;
  endtask

  initial begin
    void'($urandom(32'd5150));
    @(negedge clk);
    modelStep();
    @(posedge clk); @(negedge clk);
    checkAll();                         // R11 reset state
    cyc(0, 0, 0);
    rst = 0;
    cyc(0, 0, 0);

    // R2: x4 forward and reverse, hold longer than the pulse
    phaseTag = "R2"; pulseWidth = 3;
    walk(1, 8, 5, 0);
    walk(-1, 8, 5, 0);

    // R1 and R3: x2 pin dominates in both x4/x1 settings
    phaseTag = "R3"; x2SelN = 0; x4Sel = 1;
    walk(1, 8, 5, 0);
    phaseTag = "R1"; x4Sel = 0;
    walk(-1, 8, 5, 0);

    // R4: x1 mode
    phaseTag = "R4"; x2SelN = 1; x4Sel = 0;
    walk(1, 8, 5, 0);
    walk(-1, 8, 5, 0);

    // R7 and R8: index high while walking, x1 then x4
    phaseTag = "R8";
    walk(1, 8, 5, 1);
    walk(-1, 8, 5, 1);
    x4Sel = 1;
    walk(1, 8, 5, 1);
    walk(-1, 8, 5, 1);

    // R6: widths 0, 1 and 7
    phaseTag = "R6";
    pulseWidth = 0; walk(1, 4, 3, 0);
    pulseWidth = 1; walk(1, 4, 2, 0);
    pulseWidth = 7; walk(-1, 4, 9, 1);

    // R9: double change, then recovery and clearing by reset
    phaseTag = "R9";
    pos = (pos + 2) % 4;
    cyc(phaseA(pos), phaseB(pos), 1);
    cyc(phaseA(pos), phaseB(pos), 1);
    walk(1, 3, 8, 0);
    doReset();
    cyc(phaseA(pos), phaseB(pos), 0);

    // R10: edges closer than the width
    phaseTag = "R10"; pulseWidth = 6;
    walk(1, 6, 3, 1);
    walk(-1, 6, 2, 0);
    walk(1, 1, 10, 0);

    // random walk in all modes
    phaseTag = "R2";
    for (int n = 0; n < 1500; n++) begin
      int r, hold;
      r = int'($urandom_range(0, 99));
      if (n % 100 == 0) begin
        x2SelN = 1'($urandom_range(0, 1));
        x4Sel  = 1'($urandom_range(0, 1));
        pulseWidth = 16'($urandom_range(0, 4));
      end
      hold = int'($urandom_range(2, 8));
      if (r < 4) begin
        phaseTag = "R9";
        pos = (pos + 2) % 4;
        cyc(phaseA(pos), phaseB(pos), 1'($urandom_range(0, 1)));
        for (int k = 1; k < hold; k++) cyc(phaseA(pos), phaseB(pos), 0);
      end else begin
        phaseTag = "R10";
        step((r < 52) ? 1 : -1, hold, 1'($urandom_range(0, 1)));
      end
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule